// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block sits between a host register port and a raw NAND flash bus. The host loads a control word, up to eight address bytes, a byte count and a command word. The command word holds separate enables for a command-latch cycle, a run of address-latch cycles and a data phase. The engine then runs those phases on the flash pins, always in the order command, address, data. Phases whose enable is clear are skipped.

Data passes through an internal 1024-byte buffer that the host reads and writes as 32-bit words. On a read, bytes sampled from the flash bus fill the buffer upward from byte 0. On a write, bytes are taken from the buffer upward from byte 0 and strobed onto the bus. A status word reports a sticky completion flag, a queue-busy flag and the synchronised level of each ready/busy line. The completion flag also drives an interrupt output.

Top module: `nfc_engine`

## Requirements
- R1: After reset, the status word reads 0 apart from the ready/busy bits, every chip-enable output is high, both write and read strobes are high, and CLE and ALE are low.
- R2: Within one command word the enabled phases run in the order command cycle (bit 22, opcode in bits 7:0), then address cycles (bit 19), then data (bit 21). A phase whose enable bit is clear produces no strobe.
- R3: Address cycles number the value of command bits 18:16 plus one. They send bytes least significant first, starting with the register at offset 0x14 and continuing into the register at 0x18.
- R4: A command or address cycle holds CLE (command) or ALE (address) high and keeps the data lines unchanged across the rising edge of the write strobe. CLE and ALE are never high together.
- R5: A read (bit 21 set, bit 20 clear) waits until the ready/busy line selected by control bits 4:3 is high. It then pulses the read strobe once per bus word and stores each sample into the buffer from byte 0. In 16-bit mode (control bit 2) each pulse fills two bytes, low byte first.
- R6: A write (bits 21 and 20 set) drives buffer bytes from byte 0 onto the bus with one write-strobe pulse each, with CLE and ALE low. In 16-bit mode each pulse carries two bytes, low byte in bits 7:0. The read and write strobes are never low together.
- R7: The byte count is bits 9:0 of the register at 0x20. A count of 0 transfers the full 1024 bytes.
- R8: Status bit 1 (and the interrupt output) is set when a command word finishes, including one with no phase enabled. Writing 1 to status bit 1 clears it, and writing 0 leaves it set.
- R9: Status bit 3 is high from the acceptance of a command word until its last phase completes. A write to the command register at 0x24 while it is high is ignored.
- R10: Status bit 8+n shows the level of ready/busy input n.
- R11: Control bit 0 enables the chip. Chip-enable output k is low only when bit 0 is set and control bits 27:24 equal k. Control bits 27:24, 11:8, 4:3, 2 and 0 read back as written.
- R12: Writing 1 to control bit 1 aborts any running command, clears status bits 1 and 3, and reads back as 0.
- R13: Buffer byte k is host word k/4 at offset 0x400 + 4*(k/4), in bits 8*(k mod 4) upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address of the register or buffer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Completion flag |
| nf_ce_n | output | N_CE | Chip enables, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, active low |
| nf_re_n | output | 1 | Read strobe, active low |
| nf_dq_o | output | 16 | Flash data out |
| nf_dq_oe | output | 1 | Flash data output enable |
| nf_dq_i | input | 16 | Flash data in |
| nf_rb | input | N_RB | Ready/busy lines, 1 = ready |

## Verification
The hardest case to reach from the ports is a command word that arrives while an earlier one is still in flight. A read phase normally finishes in a few dozen cycles. To hold it open, the bench drives the selected ready/busy line low, so the engine parks before its first read strobe. While it is parked, the bench confirms that the busy bit is set, that no read strobe has occurred, and that a second command word produces no latch cycle once the line is released. The same parked state is used to show that a soft reset aborts the transfer before any data moves.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SU, S_PW, S_HD, S_FETCH, S_RBW, S_RLO, S_RHI, S_FIN
  } seq_st_t;

  typedef enum logic [1:0] { K_CMD, K_ADR, K_WR } cyc_kind_t;

  typedef struct packed {
    logic       data_en;
    logic       dir_wr;
    logic       cmd_en;
    logic       adr_en;
    logic [2:0] adr_last;
    logic [7:0] opcode;
  } cmd_word_t;

  localparam logic [11:0] OFS_CTL  = 12'h000;
  localparam logic [11:0] OFS_STAT = 12'h004;
  localparam logic [11:0] OFS_ALO  = 12'h014;
  localparam logic [11:0] OFS_AHI  = 12'h018;
  localparam logic [11:0] OFS_CNT  = 12'h020;
  localparam logic [11:0] OFS_CMD  = 12'h024;

endpackage

// File: rtl/nfc_buf.sv
module nfc_buf #(
  parameter int BYTES = 1024,
  localparam int WORDS = BYTES / 4,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic [3:0]    we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we[l]) mem[addr] <= wdata[8*l +: 8];
      rdata[8*l +: 8] <= mem[addr];
    end
  end

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int T_SU = 1,
  parameter int T_PW = 2,
  parameter int T_H  = 1,
  localparam int CNT_W = $clog2(BUF_BYTES),
  localparam int LFT_W = CNT_W + 1,
  localparam int WAW = CNT_W - 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             start,
  input  cmd_word_t        cmd_in,
  input  logic [63:0]      adr_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             bus16,
  input  logic             rb_ok,
  input  logic [15:0]      dq_i,
  input  logic [31:0]      buf_rdata,
  output logic [WAW-1:0]   buf_addr,
  output logic [3:0]       buf_we,
  output logic [31:0]      buf_wdata,
  output logic             busy,
  output logic             done_p,
  output logic             cle,
  output logic             ale,
  output logic             we_n,
  output logic             re_n,
  output logic [15:0]      dq_o,
  output logic             dq_oe
);

  seq_st_t          st, st_n;
  cyc_kind_t        kind, kind_n;
  logic [2:0]       idx, idx_n;
  logic [CNT_W-1:0] ptr, ptr_n;
  logic [LFT_W-1:0] left, left_n, step;
  logic [7:0]       tmr, tmr_n;
  cmd_word_t        cq, cs;
  logic [63:0]      aq, aw;
  logic [15:0]      dq_next;
  logic             rd_cap, in_cyc;

  assign cs   = (st == S_IDLE) ? cmd_in : cq;
  assign aw   = (st == S_IDLE) ? adr_in : aq;
  assign step = bus16 ? LFT_W'(2) : LFT_W'(1);
  assign busy = (st != S_IDLE);

  function automatic seq_st_t data_entry(cmd_word_t c);
    if (!c.data_en) return S_FIN;
    return c.dir_wr ? S_FETCH : S_RBW;
  endfunction

  always_comb begin
    st_n = st; kind_n = kind; idx_n = idx; ptr_n = ptr; left_n = left;
    tmr_n = tmr + 8'd1; done_p = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        ptr_n  = '0;
        left_n = (cnt_in == '0) ? LFT_W'(BUF_BYTES) : {1'b0, cnt_in};
        idx_n  = '0;
        if (cmd_in.cmd_en) begin
          st_n = S_SU; kind_n = K_CMD;
        end else if (cmd_in.adr_en) begin
          st_n = S_SU; kind_n = K_ADR;
        end else begin
          st_n = data_entry(cmd_in); kind_n = K_WR;
        end
      end
      S_SU:    if (tmr == 8'(T_SU - 1)) st_n = S_PW;
      S_PW:    if (tmr == 8'(T_PW - 1)) st_n = S_HD;
      S_HD:    if (tmr == 8'(T_H - 1)) begin
        case (kind)
          K_CMD: if (cs.adr_en) begin
            st_n = S_SU; kind_n = K_ADR; idx_n = '0;
          end else begin
            st_n = data_entry(cs); kind_n = K_WR;
          end
          K_ADR: if (idx == cs.adr_last) begin
            st_n = data_entry(cs); kind_n = K_WR;
          end else begin
            st_n = S_SU; idx_n = idx + 3'd1;
          end
          default: begin
            ptr_n  = ptr + CNT_W'(step);
            left_n = left - step;
            st_n   = (left <= step) ? S_FIN : S_FETCH;
          end
        endcase
      end
      S_FETCH: if (tmr == 8'd1) st_n = S_SU;
      S_RBW:   if (rb_ok) st_n = S_RLO;
      S_RLO:   if (tmr == 8'(T_PW - 1)) st_n = S_RHI;
      S_RHI:   if (tmr == 8'(T_H - 1)) begin
        ptr_n  = ptr + CNT_W'(step);
        left_n = left - step;
        st_n   = (left <= step) ? S_FIN : S_RLO;
      end
      S_FIN: begin
        done_p = 1'b1; st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
    if (st_n != st) tmr_n = '0;
  end

  // buffer port: engine side
  assign rd_cap    = (st == S_RLO) && (tmr == 8'(T_PW - 1));
  assign buf_addr  = ptr[CNT_W-1:2];
  assign buf_wdata = bus16 ? {2{dq_i}} : {4{dq_i[7:0]}};
  always_comb begin
    buf_we = 4'b0000;
    if (rd_cap) begin
      if (bus16) buf_we = ptr[1] ? 4'b1100 : 4'b0011;
      else       buf_we = 4'b0001 << ptr[1:0];
    end
  end

  always_comb begin
    case (kind_n)
      K_CMD:   dq_next = {8'h00, cs.opcode};
      K_ADR:   dq_next = {8'h00, aw[{idx_n, 3'b000} +: 8]};
      default: dq_next = bus16 ? buf_rdata[{ptr[1], 4'b0000} +: 16]
                               : {8'h00, buf_rdata[{ptr[1:0], 3'b000} +: 8]};
    endcase
  end

  assign in_cyc = (st_n == S_SU) || (st_n == S_PW) || (st_n == S_HD);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      st <= S_IDLE; kind <= K_CMD; idx <= '0; ptr <= '0; left <= '0; tmr <= '0;
      cq <= '0; aq <= '0;
      cle <= 1'b0; ale <= 1'b0; we_n <= 1'b1; re_n <= 1'b1;
      dq_o <= '0; dq_oe <= 1'b0;
    end else begin
      st <= st_n; kind <= kind_n; idx <= idx_n; ptr <= ptr_n;
      left <= left_n; tmr <= tmr_n;
      if (st == S_IDLE && start) begin
        cq <= cmd_in; aq <= adr_in;
      end
      cle   <= in_cyc && (kind_n == K_CMD);
      ale   <= in_cyc && (kind_n == K_ADR);
      we_n  <= (st_n != S_PW);
      re_n  <= (st_n != S_RLO);
      dq_oe <= in_cyc;
      if (st_n == S_SU && st != S_SU) dq_o <= dq_next;
    end
  end

endmodule

// File: rtl/nfc_engine.sv
module nfc_engine
  import nfc_pkg::*;
#(
  parameter int BUF_BYTES = 1024,
  parameter int N_CE = 4,
  parameter int N_RB = 4,
  parameter int T_SU = 1,
  parameter int T_PW = 2,
  parameter int T_H  = 1,
  localparam int CNT_W = $clog2(BUF_BYTES),
  localparam int WAW = CNT_W - 2,
  localparam int RBS_W = $clog2(N_RB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic [N_CE-1:0]   nf_ce_n,
  output logic              nf_cle,
  output logic              nf_ale,
  output logic              nf_we_n,
  output logic              nf_re_n,
  output logic [15:0]       nf_dq_o,
  output logic              nf_dq_oe,
  input  logic [15:0]       nf_dq_i,
  input  logic [N_RB-1:0]   nf_rb
);

  logic             ctl_en, ctl_bus16;
  logic [1:0]       ctl_rbsel;
  logic [3:0]       ctl_pgsz, ctl_cesel;
  logic [31:0]      adr_lo, adr_hi, cmd_q, rdata_q, ctl_rd, stat_rd;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, sel_buf_q;
  logic [N_RB-1:0]  rb_s1, rb_s2;

  logic             wr_ctl, wr_stat, wr_cmd, in_buf, soft_rst, start;
  logic             seq_busy, seq_done;
  cmd_word_t        cmd_in;
  logic [WAW-1:0]   e_addr, b_addr;
  logic [3:0]       e_we, b_we;
  logic [31:0]      e_wdata, b_wdata, b_rdata;

  assign wr_ctl   = reg_wr && (reg_addr == OFS_CTL);
  assign wr_stat  = reg_wr && (reg_addr == OFS_STAT);
  assign wr_cmd   = reg_wr && (reg_addr == OFS_CMD);
  assign in_buf   = (reg_addr[11:10] == 2'b01);
  assign soft_rst = wr_ctl && reg_wdata[1];
  assign start    = wr_cmd && !seq_busy && !soft_rst;

  assign cmd_in = '{data_en: reg_wdata[21], dir_wr: reg_wdata[20],
                    cmd_en: reg_wdata[22], adr_en: reg_wdata[19],
                    adr_last: reg_wdata[18:16], opcode: reg_wdata[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_en <= 1'b0; ctl_bus16 <= 1'b0; ctl_rbsel <= '0; ctl_pgsz <= '0;
      ctl_cesel <= '0; adr_lo <= '0; adr_hi <= '0; cnt_q <= '0; cmd_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_CTL: begin
          ctl_en <= reg_wdata[0]; ctl_bus16 <= reg_wdata[2];
          ctl_rbsel <= reg_wdata[4:3]; ctl_pgsz <= reg_wdata[11:8];
          ctl_cesel <= reg_wdata[27:24];
        end
        OFS_ALO: adr_lo <= reg_wdata;
        OFS_AHI: adr_hi <= reg_wdata;
        OFS_CNT: cnt_q  <= reg_wdata[CNT_W-1:0];
        OFS_CMD: if (start) cmd_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst)             done_q <= 1'b0;
    else if (seq_done)               done_q <= 1'b1;
    else if (wr_stat && reg_wdata[1]) done_q <= 1'b0;
  end
  assign irq = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_s1 <= '0; rb_s2 <= '0;
    end else begin
      rb_s1 <= nf_rb; rb_s2 <= rb_s1;
    end
  end

  for (genvar k = 0; k < N_CE; k++) begin : g_ce
    always_ff @(posedge clk) begin
      if (rst) nf_ce_n[k] <= 1'b1;
      else     nf_ce_n[k] <= !(ctl_en && (ctl_cesel == 4'(k)));
    end
  end

  assign ctl_rd = {4'b0, ctl_cesel, 12'b0, ctl_pgsz, 3'b0, ctl_rbsel,
                   ctl_bus16, 1'b0, ctl_en};
  always_comb begin
    stat_rd = '0;
    stat_rd[8 +: N_RB] = rb_s2;
    stat_rd[3] = seq_busy;
    stat_rd[1] = done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0; sel_buf_q <= 1'b0;
    end else begin
      sel_buf_q <= reg_rd && in_buf;
      if (reg_rd) begin
        case (reg_addr)
          OFS_CTL:  rdata_q <= ctl_rd;
          OFS_STAT: rdata_q <= stat_rd;
          OFS_ALO:  rdata_q <= adr_lo;
          OFS_AHI:  rdata_q <= adr_hi;
          OFS_CNT:  rdata_q <= {{(32-CNT_W){1'b0}}, cnt_q};
          OFS_CMD:  rdata_q <= cmd_q;
          default:  rdata_q <= '0;
        endcase
      end
    end
  end
  assign reg_rdata = sel_buf_q ? b_rdata : rdata_q;

  // engine owns the buffer port while a command runs
  assign b_addr  = seq_busy ? e_addr  : reg_addr[2 +: WAW];
  assign b_we    = seq_busy ? e_we    : {4{reg_wr && in_buf}};
  assign b_wdata = seq_busy ? e_wdata : reg_wdata;

  nfc_buf #(.BYTES(BUF_BYTES)) u_buf (
    .clk(clk), .we(b_we), .addr(b_addr), .wdata(b_wdata), .rdata(b_rdata)
  );

  nfc_seq #(.BUF_BYTES(BUF_BYTES), .T_SU(T_SU), .T_PW(T_PW), .T_H(T_H)) u_seq (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .start(start),
    .cmd_in(cmd_in), .adr_in({adr_hi, adr_lo}), .cnt_in(cnt_q),
    .bus16(ctl_bus16), .rb_ok(rb_s2[ctl_rbsel[RBS_W-1:0]]), .dq_i(nf_dq_i),
    .buf_rdata(b_rdata), .buf_addr(e_addr), .buf_we(e_we), .buf_wdata(e_wdata),
    .busy(seq_busy), .done_p(seq_done), .cle(nf_cle), .ale(nf_ale),
    .we_n(nf_we_n), .re_n(nf_re_n), .dq_o(nf_dq_o), .dq_oe(nf_dq_oe)
  );

endmodule

// File: rtl/nfc_engine_chk.sv
module nfc_engine_chk #(
  parameter int N_CE = 4
) (
  input logic            clk,
  input logic            rst,
  input logic [N_CE-1:0] ce_n,
  input logic            cle,
  input logic            ale,
  input logic            we_n,
  input logic            re_n,
  input logic [15:0]     dq_o,
  input logic            busy,
  input logic            soft_rst,
  input logic            done_p,
  input logic            irq
);

  a_r4_latch_hold: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> $stable(cle) && $stable(ale) && $stable(dq_o));

  a_r4_cle_ale_excl: assert property (@(posedge clk) disable iff (rst)
    !(cle && ale));

  a_r6_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    we_n || re_n);

  a_r9_idle_pins: assert property (@(posedge clk) disable iff (rst)
    !busy |-> we_n && re_n && !cle && !ale);

  a_r8_done_sets: assert property (@(posedge clk) disable iff (rst)
    done_p && !soft_rst |=> irq);

  a_r11_ce_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ce_n));

  a_r12_abort: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !busy && !irq);

endmodule

bind nfc_engine nfc_engine_chk #(.N_CE(N_CE)) u_chk (
  .clk(clk), .rst(rst), .ce_n(nf_ce_n), .cle(nf_cle), .ale(nf_ale),
  .we_n(nf_we_n), .re_n(nf_re_n), .dq_o(nf_dq_o), .busy(seq_busy),
  .soft_rst(soft_rst), .done_p(seq_done), .irq(irq)
);

// File: tb/nfc_engine_test.sv
module nfc_engine_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [3:0]  nf_ce_n;
  logic        nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
  logic [15:0] nf_dq_o, nf_dq_i;
  logic [3:0]  nf_rb = 4'hF;

  int checks = 0, fails = 0;
  int ev_n = 0, n_re = 0;
  logic [1:0]  ev_k [64];
  logic [15:0] ev_v [64];
  logic [1:0]  ex_k [64];
  logic [15:0] ex_v [64];
  int ex_n;

  always #10ns clk = ~clk;

  nfc_engine uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .nf_ce_n(nf_ce_n),
    .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
    .nf_dq_o(nf_dq_o), .nf_dq_oe(nf_dq_oe), .nf_dq_i(nf_dq_i), .nf_rb(nf_rb)
  );

  // flash model: log latched bytes, serve a read pattern
  function automatic logic [15:0] rd_pat(int i);
    return {8'hC3 ^ i[7:0], i[7:0] + 8'h11};
  endfunction
  assign nf_dq_i = rd_pat(n_re);

  always @(posedge nf_we_n) if (!rst) begin
    if (ev_n < 64) begin
      ev_k[ev_n] = nf_cle ? 2'd0 : (nf_ale ? 2'd1 : 2'd2);
      ev_v[ev_n] = nf_dq_o;
    end
    ev_n++;
  end
  always @(posedge nf_re_n) if (!rst) n_re++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] s;
    int n = 0;
    s = '0;
    while (!s[1] && n < 20000) begin
      rd(12'h004, s); n++;
    end
    chk(tag, {31'b0, s[1]}, 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stimulus vectors: ctl, command word, addr low, addr high, count
  localparam int NV = 7;
  localparam logic [143:0] VEC [NV] = '{
    {32'h0000_0001, 32'h0040_00FF, 32'h0000_0000, 32'h0000_0000, 16'd0},
    {32'h0000_0001, 32'h0048_0090, 32'h0000_00AB, 32'h0000_0000, 16'd0},
    {32'h0000_0001, 32'h004C_0000, 32'h4433_2211, 32'h0000_00A5, 16'd0},
    {32'h0000_0001, 32'h000F_0000, 32'h8765_4321, 32'hFEDC_BA98, 16'd0},
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 16'd0},
    {32'h0000_0001, 32'h0479_0080, 32'h0000_BEEF, 32'h0000_0000, 16'd6},
    {32'h0000_0005, 32'h0430_0000, 32'h0000_0000, 32'h0000_0000, 16'd4}
  };

  // expected latch sequence derived from the command fields (R2, R3, R6)
  task automatic build_exp(input logic [31:0] c, input logic [63:0] a,
                           input int cnt, input logic b16);
    ex_n = 0;
    if (c[22]) begin ex_k[ex_n] = 2'd0; ex_v[ex_n] = {8'h00, c[7:0]}; ex_n++; end
    if (c[19]) for (int i = 0; i <= int'(c[18:16]); i++) begin
      ex_k[ex_n] = 2'd1; ex_v[ex_n] = {8'h00, a[8*i +: 8]}; ex_n++;
    end
    if (c[21] && c[20]) begin
      if (b16) for (int j = 0; j < cnt; j += 2) begin
        ex_k[ex_n] = 2'd2; ex_v[ex_n] = {8'h30 + 8'(j+1), 8'h30 + 8'(j)}; ex_n++;
      end else for (int j = 0; j < cnt; j++) begin
        ex_k[ex_n] = 2'd2; ex_v[ex_n] = {8'h00, 8'h30 + 8'(j)}; ex_n++;
      end
    end
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(20ns * 190000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(3);

    // R1 reset state
    rd(12'h004, d);
    chk("R1 status", d, 32'h0000_0F00);
    chk("R1 pins", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale}, {4'hF, 4'b1100});

    // R13 buffer preload and readback
    wr(12'h400, 32'h3332_3130);
    wr(12'h404, 32'h3736_3534);
    rd(12'h404, d);
    chk("R13 buffer word", d, 32'h3736_3534);

    // vector table: R2 R3 R4 R6 R8
    for (int v = 0; v < NV; v++) begin
      logic [143:0] t;
      t = VEC[v];
      wr(12'h000, t[143:112]);
      wr(12'h014, t[79:48]);
      wr(12'h018, t[47:16]);
      wr(12'h020, {16'h0, t[15:0]});
      wr(12'h004, 32'h2);
      ev_n = 0;
      build_exp(t[111:80], {t[47:16], t[79:48]}, int'(t[15:0]), t[114]);
      wr(12'h024, t[111:80]);
      wait_done($sformatf("R8 done vec%0d", v));
      chk($sformatf("R2 event count vec%0d", v), ev_n, ex_n);
      for (int e = 0; e < ex_n && e < ev_n; e++)
        chk($sformatf("R2/R3/R6 vec%0d event%0d", v, e),
            {14'b0, ev_k[e], ev_v[e]}, {14'b0, ex_k[e], ex_v[e]});
    end

    // R11 chip enable decode and readback
    wr(12'h000, 32'h0200_0A19);
    idle(2);
    chk("R11 ce select", {28'b0, nf_ce_n}, 32'h0000_000B);
    rd(12'h000, d);
    chk("R11 ctl readback", d, 32'h0200_0A19);
    wr(12'h000, 32'h0200_0000);
    idle(2);
    chk("R11 ce disabled", {28'b0, nf_ce_n}, 32'h0000_000F);

    // R10 ready/busy reflection
    nf_rb = 4'b0101;
    idle(4);
    rd(12'h004, d);
    chk("R10 rb bits", {28'b0, d[11:8]}, 32'h5);

    // R5 R9: read stalls on busy line, second command ignored
    nf_rb = 4'b1110;
    wr(12'h000, 32'h0000_0001);
    wr(12'h020, 32'd8);
    wr(12'h004, 32'h2);
    n_re = 0; ev_n = 0;
    wr(12'h024, 32'h0420_0000);
    idle(20);
    chk("R5 no strobe while busy line low", n_re, 0);
    rd(12'h004, d);
    chk("R9 busy bit", {31'b0, d[3]}, 32'd1);
    wr(12'h024, 32'h0040_0077);
    nf_rb = 4'hF;
    wait_done("R8 read done");
    idle(30);
    chk("R9 ignored command", ev_n, 0);
    chk("R5 read pulses", n_re, 8);
    rd(12'h400, d);
    chk("R5 R13 word0", d, 32'h1413_1211);
    rd(12'h404, d);
    chk("R5 R13 word1", d, 32'h1817_1615);

    // R8 write-one-to-clear
    chk("R8 irq set", {31'b0, irq}, 32'd1);
    wr(12'h004, 32'h0);
    rd(12'h004, d);
    chk("R8 write 0 keeps flag", {31'b0, d[1]}, 32'd1);
    wr(12'h004, 32'h2);
    rd(12'h004, d);
    chk("R8 write 1 clears flag", {31'b0, d[1]}, 32'd0);

    // R5 16-bit read
    wr(12'h000, 32'h0000_0005);
    wr(12'h020, 32'd4);
    n_re = 0;
    wr(12'h024, 32'h0420_0000);
    wait_done("R8 16-bit read done");
    chk("R5 16-bit pulses", n_re, 2);
    rd(12'h400, d);
    chk("R5 16-bit word0", d, 32'hC212_C311);

    // R7 count 0 = full buffer
    wr(12'h000, 32'h0000_0001);
    wr(12'h020, 32'd0);
    wr(12'h004, 32'h2);
    n_re = 0;
    wr(12'h024, 32'h0420_0000);
    wait_done("R8 full read done");
    chk("R7 full-buffer pulses", n_re, 1024);
    rd(12'h7FC, d);
    chk("R7 last word", d, 32'h100F_0E0D);

    // R12 soft reset aborts a stalled read
    nf_rb = 4'b1110;
    wr(12'h020, 32'd4);
    n_re = 0;
    wr(12'h024, 32'h0420_0000);
    idle(5);
    wr(12'h000, 32'h0000_0003);
    rd(12'h004, d);
    chk("R12 busy and done cleared", {30'b0, d[3], d[1]}, 32'd0);
    rd(12'h000, d);
    chk("R12 reset bit reads 0", d, 32'h0000_0001);
    nf_rb = 4'hF;
    idle(20);
    chk("R12 no transfer after abort", n_re, 0);

    summary();
    $finish;
  end

endmodule